// File: doc/BRIEF.md
# ADC multiplexer schedule sequencer

This block plays back an acquisition schedule that lives in an external control RAM with synchronous read. The schedule is divided into fixed-length sample slots. For each slot the block fetches one 48-bit control word and splits it into four parts: nine analog multiplexer select lines, a calibration-table read address, two sign-invert flags (one for each ADC) and a result-store base address. The table index counts up and wraps after 160, 40 or 10 entries, as the cycle-length mode selects. The 160-entry mode covers one 12 kHz period when a slot lasts 520 ns.

An ADC result comes back one slot after its channel was selected. For that reason the result-side fields of each word (invert flags and store address) take effect one slot after the mux-side fields of the same word. In each armed slot the block accepts one pair of samples (ADC A and ADC B) on a valid/ready stream. It negates, with saturation, the samples whose flag is set. It then emits two result writes, A first and then B, on a second valid/ready stream. The top bit of the write address tells ADC A from ADC B.

Back-pressure rules: a write stays presented with stable address and data until `res_ready` is high, and `smp_ready` stays low while any write of the previous pair is pending. A sample pair is accepted on a clock where `smp_valid` and `smp_ready` are both high. A write is taken on a clock where `res_valid` and `res_ready` are both high.

Top module: `adc_slot_sequencer`

## Requirements
- R1: `mux_sel` and `cal_addr` change only at a slot boundary. A slot is SLOT_CLKS clocks long. After a restart the first boundary update happens on the SLOT_CLKS-th rising edge that has no restart, and the next one SLOT_CLKS edges later.
- R2: Field decoding of a word w: mux_sel[2:0]=w[2:0], mux_sel[5:3]=w[6:4], mux_sel[6]=w[8], mux_sel[7]=w[12], mux_sel[8]=w[16], cal_addr=w[39:32]. Bits 3, 7, 9-11, 13-15, 17-23, 25-27 and 29-31 have no effect on any output.
- R3: `tbl_addr` presents the index of the entry to be applied at the next boundary. `tbl_data` is taken to return that word one clock later. Entries are applied in order 0,1,2,... and wrap to 0 after the last one. The number of entries is 160 for mode 2'b00, 40 for mode 2'b01, and 10 for modes 2'b10 and 2'b11.
- R4: Synchronous `rst`, or any change of `mode`, restarts the schedule at entry 0. It clears `mux_sel` and `cal_addr` to 0 until the first boundary and drops any pending result writes.
- R5: A pair accepted in the slot that shows entry k on the mux is tagged with entry k-1: store base w[47:40], ADC A invert flag w[24], ADC B invert flag w[28]. In the slot that shows entry 0 after a wrap, the tag comes from the last entry.
- R6: `smp_ready` is low from a restart until the end of the slot that shows entry 0.
- R7: At most one pair is accepted per slot, and `smp_ready` is low in the last clock of every slot. Each accepted pair yields exactly two writes: ADC A first with res_addr={1'b0, base}, then ADC B with res_addr={1'b1, base}.
- R8: A flagged sample is written as its two's-complement negation. The most negative code is written as the most positive code. An unflagged sample is written unchanged.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_addr` and `res_data` hold. `smp_ready` is low while `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Cycle-length mode: 00=160, 01=40, 10/11=10 entries |
| tbl_addr | output | IDX_W | Control RAM read address |
| tbl_data | input | 48 | Control RAM read data, one clock after the address |
| mux_sel | output | 9 | Analog multiplexer select lines |
| cal_addr | output | 8 | Calibration-table read address |
| smp_valid | input | 1 | Sample pair valid |
| smp_ready | output | 1 | Sample pair ready |
| smp_a | input | SAMPLE_W | Signed sample from ADC A |
| smp_b | input | SAMPLE_W | Signed sample from ADC B |
| res_valid | output | 1 | Result write valid |
| res_ready | input | 1 | Result write ready |
| res_addr | output | 9 | Result-store address, top bit selects ADC B |
| res_data | output | SAMPLE_W | Sign-corrected sample |

## Verification
The assertions assume that SLOT_CLKS is at least 2, so that a boundary is never followed by another on the next clock. They also assume the RAM answers with exactly one clock of latency, so the data seen on the boundary clock belongs to the address that was held through the slot. The bench keeps within these limits: it runs an 8-clock slot and uses a RAM model with a single register stage. It changes `mode` or reset only once the result stream has drained, so no write is dropped in mid-transfer. It stalls `res_ready` only for short windows that end well before the next pair is offered.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CTL_W  = 48;
  localparam int SEL_W  = 9;
  localparam int CAL_W  = 8;
  localparam int BASE_W = 8;

  typedef enum logic [1:0] {
    CYC_LONG      = 2'b00,
    CYC_MID       = 2'b01,
    CYC_SHORT     = 2'b10,
    CYC_SHORT_ALT = 2'b11
  } cyc_mode_e;

  // Fields of one schedule word after decoding.
  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [CAL_W-1:0]  cal;
    logic              inv_a;
    logic              inv_b;
    logic [BASE_W-1:0] base;
  } slot_fields_t;

endpackage

// File: rtl/seq_slot_timer.sv
module seq_slot_timer #(
  parameter int SLOT_CLKS = 130   // must be >= 2
) (
  input  logic clk,
  input  logic restart,
  output logic at_bnd
);
  localparam int CNT_W = (SLOT_CLKS > 2) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CLKS - 1);

  logic [CNT_W-1:0] cnt;

  assign at_bnd = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (restart)     cnt <= '0;
    else if (at_bnd) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R1: a boundary clock is never followed straight away by another one
  a_r1_bnd_spacing: assert property (@(posedge clk) disable iff (restart)
    at_bnd |=> !at_bnd);

  // R1: the counter stays inside one slot
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (restart)
    cnt <= LAST);

endmodule

// File: rtl/seq_entry_counter.sv
module seq_entry_counter
  import adc_seq_pkg::*;
#(
  parameter int IDX_W     = 9,
  parameter int LEN_LONG  = 160,
  parameter int LEN_MID   = 40,
  parameter int LEN_SHORT = 10
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             step,
  input  cyc_mode_e        mode,
  output logic [IDX_W-1:0] nxt_idx
);
  logic [IDX_W-1:0] last_idx;

  always_comb begin
    case (mode)
      CYC_LONG: last_idx = IDX_W'(LEN_LONG - 1);
      CYC_MID:  last_idx = IDX_W'(LEN_MID - 1);
      default:  last_idx = IDX_W'(LEN_SHORT - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (restart)
      nxt_idx <= '0;
    else if (step)
      nxt_idx <= (nxt_idx == last_idx) ? '0 : nxt_idx + 1'b1;
  end

  // R3: the index never leaves the table of the selected mode
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (restart)
    nxt_idx <= last_idx);

  // R3: stepping past the last entry lands on entry 0
  a_r3_wrap: assert property (@(posedge clk) disable iff (restart)
    (step && nxt_idx == last_idx) |=> (nxt_idx == '0));

endmodule

// File: rtl/seq_sign_fix.sv
module seq_sign_fix #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inv,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] dout
);
  localparam logic [SAMPLE_W-1:0] MIN_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MAX_CODE = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic [SAMPLE_W-1:0] negated;

  always_comb begin
    if (din == MIN_CODE) negated = MAX_CODE;
    else                 negated = (~din) + 1'b1;
    dout = inv ? negated : din;
  end

  // R8: a flagged sample never comes out as the most negative code
  a_r8_no_min: assert property (@(posedge clk) disable iff (rst)
    inv |-> (dout != MIN_CODE));

endmodule

// File: rtl/seq_result_out.sv
module seq_result_out #(
  parameter int SAMPLE_W = 16,
  parameter int BASE_W   = 8
) (
  input  logic                clk,
  input  logic                restart,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] din_a,
  input  logic [SAMPLE_W-1:0] din_b,
  input  logic [BASE_W-1:0]   base,
  output logic                busy,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [BASE_W:0]     res_addr,
  output logic [SAMPLE_W-1:0] res_data
);
  typedef enum logic [1:0] {OUT_IDLE, OUT_A, OUT_B} out_state_e;

  out_state_e          state;
  logic [SAMPLE_W-1:0] hold_a;
  logic [SAMPLE_W-1:0] hold_b;
  logic [BASE_W-1:0]   hold_base;

  always_ff @(posedge clk) begin
    if (restart) begin
      state     <= OUT_IDLE;
      hold_a    <= '0;
      hold_b    <= '0;
      hold_base <= '0;
    end else begin
      case (state)
        OUT_IDLE: if (load) begin
          state     <= OUT_A;
          hold_a    <= din_a;
          hold_b    <= din_b;
          hold_base <= base;
        end
        OUT_A:   if (res_ready) state <= OUT_B;
        OUT_B:   if (res_ready) state <= OUT_IDLE;
        default: state <= OUT_IDLE;
      endcase
    end
  end

  assign busy      = (state != OUT_IDLE);
  assign res_valid = busy;
  assign res_addr  = {(state == OUT_B), hold_base};
  assign res_data  = (state == OUT_B) ? hold_b : hold_a;

  // R9: a stalled write holds its address and data
  a_r9_hold: assert property (@(posedge clk) disable iff (restart)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_data)));

  // R7: the ADC A write is always followed by the ADC B write
  a_r7_a_then_b: assert property (@(posedge clk) disable iff (restart)
    (res_valid && res_ready && !res_addr[BASE_W]) |=> (res_valid && res_addr[BASE_W]));

endmodule

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer
  import adc_seq_pkg::*;
#(
  parameter int SLOT_CLKS = 130,
  parameter int SAMPLE_W  = 16,
  parameter int IDX_W     = 9,
  parameter int LEN_LONG  = 160,
  parameter int LEN_MID   = 40,
  parameter int LEN_SHORT = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  output logic [IDX_W-1:0]    tbl_addr,
  input  logic [CTL_W-1:0]    tbl_data,
  output logic [SEL_W-1:0]    mux_sel,
  output logic [CAL_W-1:0]    cal_addr,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_a,
  input  logic [SAMPLE_W-1:0] smp_b,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [BASE_W:0]     res_addr,
  output logic [SAMPLE_W-1:0] res_data
);
  localparam int LANES = 2;

  cyc_mode_e    cyc_mode;
  cyc_mode_e    mode_q;
  logic         restart;
  logic         at_bnd;
  slot_fields_t word_f;
  slot_fields_t mux_f;
  logic         mux_armed;
  logic         res_inv_a, res_inv_b, res_armed, taken;
  logic [BASE_W-1:0] res_base;
  logic         out_busy;
  logic         accept;
  logic [SAMPLE_W-1:0] lane_in  [LANES];
  logic [SAMPLE_W-1:0] lane_out [LANES];
  logic [LANES-1:0]    lane_inv;
  logic         word_unused;

  assign cyc_mode = cyc_mode_e'(mode);
  assign restart  = rst || (cyc_mode != mode_q);

  always_ff @(posedge clk) mode_q <= cyc_mode;

  // Decode: the mux and calibration fields are applied at once, the rest one slot later
  always_comb begin
    word_f.sel   = {tbl_data[16], tbl_data[12], tbl_data[8], tbl_data[6:4], tbl_data[2:0]};
    word_f.cal   = tbl_data[39:32];
    word_f.inv_a = tbl_data[24];
    word_f.inv_b = tbl_data[28];
    word_f.base  = tbl_data[47:40];
  end
  assign word_unused = ^{tbl_data[3], tbl_data[7], tbl_data[11:9], tbl_data[15:13],
                         tbl_data[23:17], tbl_data[27:25], tbl_data[31:29]};

  seq_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
    .clk(clk), .restart(restart), .at_bnd(at_bnd)
  );

  seq_entry_counter #(
    .IDX_W(IDX_W), .LEN_LONG(LEN_LONG), .LEN_MID(LEN_MID), .LEN_SHORT(LEN_SHORT)
  ) u_entry (
    .clk(clk), .restart(restart), .step(at_bnd), .mode(cyc_mode), .nxt_idx(tbl_addr)
  );

  // Two stages: mux side (current word), result side (previous word)
  always_ff @(posedge clk) begin
    if (restart) begin
      mux_f     <= '0;
      mux_armed <= 1'b0;
      res_inv_a <= 1'b0;
      res_inv_b <= 1'b0;
      res_base  <= '0;
      res_armed <= 1'b0;
      taken     <= 1'b0;
    end else if (at_bnd) begin
      mux_f     <= word_f;
      mux_armed <= 1'b1;
      res_inv_a <= mux_f.inv_a;
      res_inv_b <= mux_f.inv_b;
      res_base  <= mux_f.base;
      res_armed <= mux_armed;
      taken     <= 1'b0;
    end else if (accept) begin
      taken <= 1'b1;
    end
  end

  assign mux_sel   = mux_f.sel;
  assign cal_addr  = mux_f.cal;
  assign smp_ready = res_armed && !taken && !out_busy && !at_bnd;
  assign accept    = smp_valid && smp_ready;

  assign lane_in[0] = smp_a;
  assign lane_in[1] = smp_b;
  assign lane_inv   = {res_inv_b, res_inv_a};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    seq_sign_fix #(.SAMPLE_W(SAMPLE_W)) u_fix (
      .clk(clk), .rst(rst), .inv(lane_inv[g]), .din(lane_in[g]), .dout(lane_out[g])
    );
  end

  seq_result_out #(.SAMPLE_W(SAMPLE_W), .BASE_W(BASE_W)) u_out (
    .clk(clk), .restart(restart), .load(accept),
    .din_a(lane_out[0]), .din_b(lane_out[1]), .base(res_base),
    .busy(out_busy), .res_valid(res_valid), .res_ready(res_ready),
    .res_addr(res_addr), .res_data(res_data)
  );

  // R1: mux-side outputs move only after a boundary or a restart
  a_r1_mux_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(at_bnd) && !$past(restart)) |-> ($stable(mux_sel) && $stable(cal_addr)));

  // R4: a restart clears the mux outputs and drops the result stream
  a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (mux_sel == '0 && cal_addr == '0 && !res_valid));

  // R7: one accepted pair per slot
  a_r7_one_per_slot: assert property (@(posedge clk) disable iff (restart)
    accept |=> !smp_ready);

  // R9: no new pair is taken while a write is pending
  a_r9_no_ready_busy: assert property (@(posedge clk) disable iff (restart)
    res_valid |-> !smp_ready);

  // R6: the result side is not armed in the first clock after a restart
  a_r6_unarmed_after_restart: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> !smp_ready);

endmodule

// File: tb/test_adc_slot_sequencer.sv
module test_adc_slot_sequencer;
  localparam int S  = 8;
  localparam int SW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [8:0]  tbl_addr;
  logic [47:0] tbl_data;
  logic [8:0]  mux_sel;
  logic [7:0]  cal_addr;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [SW-1:0] smp_a = '0, smp_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [8:0]  res_addr;
  logic [SW-1:0] res_data;

  int checks = 0;
  int errors = 0;
  logic [8:0]    q_addr[$];
  logic [SW-1:0] q_data[$];

  always #2 clk = ~clk;

  adc_slot_sequencer #(.SLOT_CLKS(S), .SAMPLE_W(SW)) i_adc_slot_sequencer (
    .clk(clk), .rst(rst), .mode(mode), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .mux_sel(mux_sel), .cal_addr(cal_addr), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_a(smp_a), .smp_b(smp_b), .res_valid(res_valid), .res_ready(res_ready),
    .res_addr(res_addr), .res_data(res_data)
  );

  // Expected fields of table entry i
  function automatic logic [8:0] sel_of(int i);  return 9'(i + 1);         endfunction
  function automatic logic [7:0] cal_of(int i);  return 8'(i * 7 + 3);     endfunction
  function automatic logic [7:0] base_of(int i); return 8'(200 - i);       endfunction
  function automatic bit inv_a_of(int i); return (i % 3) == 0; endfunction
  function automatic bit inv_b_of(int i); return (i % 4) == 1; endfunction

  function automatic logic [47:0] word_of(int i);
    logic [47:0] w;
    logic [8:0]  s;
    s = sel_of(i);
    // R2: bits that must be ignored are filled with a varying pattern
    w = (i % 2 == 1) ? 48'h0000_EEEE_FE88 : 48'h0000_2222_2A08;
    w[2:0] = s[2:0]; w[6:4] = s[5:3]; w[8] = s[6]; w[12] = s[7]; w[16] = s[8];
    w[24] = inv_a_of(i); w[28] = inv_b_of(i);
    w[39:32] = cal_of(i); w[47:40] = base_of(i);
    return w;
  endfunction

  function automatic logic [SW-1:0] samp_a(int j);
    return (j % 11 == 0) ? 16'h8000 : 16'(j * 257 - 20000);
  endfunction
  function automatic logic [SW-1:0] samp_b(int j);
    return (j % 13 == 1) ? 16'h8000 : 16'(15000 - j * 311);
  endfunction
  function automatic logic [SW-1:0] fix(logic [SW-1:0] x, bit inv);
    if (!inv) return x;
    if (x == 16'h8000) return 16'h7FFF;
    return (~x) + 16'd1;
  endfunction

  // Control RAM model with one clock of read latency
  always_ff @(posedge clk) tbl_data <= word_of(int'(tbl_addr));

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Result stream monitor
  logic          prev_stall = 1'b0;
  logic [8:0]    prev_addr;
  logic [SW-1:0] prev_data;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(res_valid && res_addr == prev_addr && res_data == prev_data,
              "R9", "stalled write held", int'(res_data), int'(prev_data));
      if (res_valid && res_ready) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R7", "unexpected write addr", int'(res_addr), -1);
        end else begin
          check(res_addr == q_addr[0], "R5 R7", "write addr", int'(res_addr), int'(q_addr[0]));
          check(res_data == q_data[0], "R5 R8", "write data", int'(res_data), int'(q_data[0]));
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
        end
      end
      prev_stall = res_valid && !res_ready;
      prev_addr  = res_addr;
      prev_data  = res_data;
    end else begin
      prev_stall = 1'b0;
    end
  end

  // Runs n slots after a restart edge; len is the table length of the mode
  task automatic run_sched(int n, int len);
    bit pre_ok = 1'b1;
    bit drop;
    for (int c = 0; c < S - 1; c++) begin
      @(posedge clk); #1;
      if (mux_sel != 0 || cal_addr != 0 || smp_ready) pre_ok = 1'b0;
    end
    check(pre_ok, "R4 R6", "cleared before first boundary", int'(mux_sel), 0);
    for (int j = 0; j < n; j++) begin
      int  e      = j % len;
      int  tag    = (e + len - 1) % len;
      bit  do_smp = (j % 5) != 4;
      bit  stall  = (j % 7) == 3;
      bit  mux_ok = 1'b1;
      bit  acc    = 1'b0;
      drop = 1'b0;
      for (int c = 0; c < S; c++) begin
        @(posedge clk); #1;
        if (drop) begin smp_valid = 1'b0; drop = 1'b0; end
        if (mux_sel != sel_of(e) || cal_addr != cal_of(e)) mux_ok = 1'b0;
        if (res_valid)
          check(!smp_ready, "R9", "ready while write pending", int'(smp_ready), 0);
        if (c == S - 1)
          check(!smp_ready, "R7", "ready in last clock of slot", int'(smp_ready), 0);
        if (j == 0 && smp_ready)
          check(1'b0, "R6", "ready in first slot", 1, 0);
        res_ready = !(stall && (c == 2 || c == 3));
        if (c == 1 && do_smp) begin
          smp_valid = 1'b1;
          smp_a = samp_a(j);
          smp_b = samp_b(j);
        end
        if (smp_valid && smp_ready) begin
          acc  = 1'b1;
          drop = 1'b1;
          q_addr.push_back({1'b0, base_of(tag)});
          q_data.push_back(fix(smp_a, inv_a_of(tag)));
          q_addr.push_back({1'b1, base_of(tag)});
          q_data.push_back(fix(smp_b, inv_b_of(tag)));
        end
        if (c == S - 1) smp_valid = 1'b0;
      end
      check(mux_ok, "R1 R2 R3", "mux fields over slot", int'(mux_sel), int'(sel_of(e)));
      if (j >= 1 && do_smp)
        check(acc, "R7", "pair accepted in armed slot", int'(acc), 1);
    end
  endtask

  task automatic drain();
    res_ready = 1'b1;
    smp_valid = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    check(q_addr.size() == 0, "R7", "all expected writes seen", q_addr.size(), 0);
  endtask

  task automatic change_mode(logic [1:0] m);
    mode = m;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(mux_sel == 0 && !smp_ready && !res_valid, "R4", "reset state", int'(mux_sel), 0);
    rst = 1'b0;
    run_sched(165, 160);   // long mode with wrap
    drain();
    change_mode(2'b01);
    run_sched(45, 40);
    drain();
    change_mode(2'b10);
    run_sched(25, 10);
    drain();
    change_mode(2'b11);
    run_sched(12, 10);
    drain();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    run_sched(6, 10);
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule